// File: doc/BRIEF.md
# Background Flash Stream Prefetcher

This block pulls a contiguous run of words out of a flash read port and hands them to a streaming FIFO. It does this only when the flash is not busy with anything else. Software programs a byte start address and then writes a transfer count. The engine then waits for cycles in which the flash port reports it is free. In each such cycle it may place one word read, as long as the FIFO has room and no earlier stream read is still waiting for its data. Each returned word is pushed into the FIFO. The count register drops by one per pushed word. The stream ends when the count reaches zero.

Writing zero to the count cancels a running stream at once. A read already sent to the flash is marked stale, and its data is thrown away when it returns. Software can program a new address and count straight away. The new stream may send its first read while up to `MAX_STALE` stale reads are still in flight, because the flash returns responses in the order the reads were issued. A parameter chooses whether FIFO pushes come straight from the flash response or go through a register stage.

Top module: `flash_stream_engine`

## Requirements
- R1: After reset, the count and the address registers both read zero, and neither `fl_req` nor `fifo_push` is asserted.
- R2: A register write with `reg_sel`=1 loads bits 21:0 of `reg_wdata` into the count, and bits above 21 are ignored. A nonzero count starts a stream. A read with `reg_sel`=1 returns the number of transfers still remaining, zero-extended, and a read with `reg_sel`=0 returns the current stream address.
- R3: `fl_req` is asserted only in cycles where `fl_idle` is high, so foreground accesses always win.
- R4: Successive stream reads use addresses starting at the programmed address and rising by 4 per issued read. Each word is requested once. After a stream, the address register reads start + 4 × transfers.
- R5: Each accepted response is pushed into the FIFO with its data unchanged and in issue order, and the count decrements by exactly one. Once the count is zero, no further read is issued.
- R6: Writing zero to the count makes it read zero from the next cycle, and no new read is issued while it stays zero.
- R7: No read is issued while `fifo_full` is high, while a live stream read is outstanding, or in a cycle with a register write.
- R8: The response to a read that was in flight at a zero write is never pushed into the FIFO, and it does not change the count of any later stream.
- R9: After a cancel, a new stream issues its first read without waiting for stale responses, provided fewer than `MAX_STALE` (default 3) stale reads are in flight. With `MAX_STALE` stale reads in flight, issue is held.
- R10: A write with `reg_sel`=0 loads the stream address directly, with the two low bits forced to zero (word aligned).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 address, 1 count |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register value |
| fl_idle | input | 1 | Flash port free of foreground accesses this cycle |
| fl_req | output | 1 | Stream word read request |
| fl_addr | output | AW (24) | Byte address of the requested word |
| fl_rvalid | input | 1 | Flash read response valid (in issue order) |
| fl_rdata | input | DW (32) | Flash read response data |
| fifo_full | input | 1 | Streaming FIFO cannot take a word |
| fifo_push | output | 1 | Push strobe to the FIFO |
| fifo_wdata | output | DW (32) | Word pushed into the FIFO |

## Verification
The properties assume that the flash raises `fl_rvalid` only for reads that were actually issued, one response per read, in issue order. They also assume that `fifo_full` rises only as a result of this engine's own pushes. The bench flash model queues every sampled request and answers it after a programmable latency, strictly first in, first out. It never produces an unrequested response. The FIFO full flag is driven only by scenario tasks, and only while no response is pending.

// File: rtl/fse_pkg.sv
`timescale 1ns/1ps
package fse_pkg;
   localparam int REG_W = 32;

   typedef enum logic {
      SEL_ADDR  = 1'b0,
      SEL_COUNT = 1'b1
   } fse_sel_e;

   function automatic int unsigned fse_step(input int unsigned dw);
      return dw / 8;
   endfunction
endpackage

// File: rtl/fse_regs.sv
`timescale 1ns/1ps
module fse_regs
   import fse_pkg::*;
#(
   parameter int AW   = 24,
   parameter int CW   = 22,
   parameter int STEP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              sel,
   input  logic [REG_W-1:0]  wdata,
   input  logic              adv,
   input  logic              dec,
   output logic [AW-1:0]     addr,
   output logic [CW-1:0]     cnt,
   output logic              abort,
   output logic [REG_W-1:0]  rdata
);
   localparam logic [AW-1:0] ALIGN_MASK = ~AW'(STEP - 1);
   localparam logic [AW-1:0] STEP_V     = AW'(STEP);

   logic [AW-1:0] addr_q, addr_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic          wr_addr, wr_cnt;

   assign wr_addr = wr_en && (sel == SEL_ADDR);
   assign wr_cnt  = wr_en && (sel == SEL_COUNT);
   assign abort   = wr_cnt && (wdata[CW-1:0] == '0);

   always_comb begin
      addr_d = addr_q;
      if (wr_addr)  addr_d = AW'(wdata) & ALIGN_MASK;
      else if (adv) addr_d = addr_q + STEP_V;
   end

   always_comb begin
      cnt_d = cnt_q;
      if (wr_cnt)                  cnt_d = wdata[CW-1:0];
      else if (dec && cnt_q != '0) cnt_d = cnt_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         cnt_q  <= '0;
      end else begin
         addr_q <= addr_d;
         cnt_q  <= cnt_d;
      end
   end

   generate
      if (AW < REG_W) begin : g_hi_bits
         logic unused_hi;
         assign unused_hi = ^wdata[REG_W-1:AW];
      end
   endgenerate

   assign addr  = addr_q;
   assign cnt   = cnt_q;
   assign rdata = (sel == SEL_ADDR) ? REG_W'(addr_q) : REG_W'(cnt_q);
endmodule

// File: rtl/fse_tracker.sv
`timescale 1ns/1ps
module fse_tracker #(
   parameter int MAX_STALE = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic issue,
   input  logic rvalid,
   input  logic abort,
   output logic live,
   output logic stale_full,
   output logic accept
);
   localparam int SW = $clog2(MAX_STALE + 1);
   localparam logic [SW-1:0] STALE_MAX = SW'(MAX_STALE);

   logic          live_q, live_d;
   logic [SW-1:0] stale_q, stale_d;
   logic          hit_stale, hit_live, to_stale;

   // responses return in order: stale reads drain first
   assign hit_stale = rvalid && (stale_q != '0);
   assign hit_live  = rvalid && (stale_q == '0) && live_q;
   assign accept    = hit_live && !abort;
   assign to_stale  = abort && live_q && !hit_live;

   always_comb begin
      live_d = live_q;
      if (issue)                  live_d = 1'b1;
      else if (hit_live || abort) live_d = 1'b0;
   end

   always_comb begin
      stale_d = stale_q;
      case ({hit_stale, to_stale})
         2'b10:   stale_d = stale_q - 1'b1;
         2'b01:   stale_d = stale_q + 1'b1;
         default: stale_d = stale_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q  <= 1'b0;
         stale_q <= '0;
      end else begin
         live_q  <= live_d;
         stale_q <= stale_d;
      end
   end

   assign live       = live_q;
   assign stale_full = (stale_q == STALE_MAX);
endmodule

// File: rtl/flash_stream_engine.sv
`timescale 1ns/1ps
module flash_stream_engine
   import fse_pkg::*;
#(
   parameter int AW        = 24,
   parameter int DW        = 32,
   parameter int CW        = 22,
   parameter int MAX_STALE = 3,
   parameter bit PUSH_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic              reg_sel,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              fl_idle,
   output logic              fl_req,
   output logic [AW-1:0]     fl_addr,
   input  logic              fl_rvalid,
   input  logic [DW-1:0]     fl_rdata,
   input  logic              fifo_full,
   output logic              fifo_push,
   output logic [DW-1:0]     fifo_wdata
);
   localparam int STEP = fse_step(DW);

   generate
      if (AW > REG_W || AW < 4)   begin : g_bad_aw  $error("AW out of range");   end
      if (CW > REG_W || CW < 1)   begin : g_bad_cw  $error("CW out of range");   end
      if (DW % 8 != 0 || DW < 16) begin : g_bad_dw  $error("DW must be bytes"); end
      if (MAX_STALE < 1)          begin : g_bad_ms  $error("MAX_STALE >= 1");   end
   endgenerate

   logic [AW-1:0] addr_cur;
   logic [CW-1:0] cnt_cur;
   logic          abort, live, stale_full, accept, issue, push_busy;

   fse_regs #(.AW(AW), .CW(CW), .STEP(STEP)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (reg_wr_en),
      .sel   (reg_sel),
      .wdata (reg_wdata),
      .adv   (issue),
      .dec   (accept),
      .addr  (addr_cur),
      .cnt   (cnt_cur),
      .abort (abort),
      .rdata (reg_rdata)
   );

   fse_tracker #(.MAX_STALE(MAX_STALE)) u_trk (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue      (issue),
      .rvalid     (fl_rvalid),
      .abort      (abort),
      .live       (live),
      .stale_full (stale_full),
      .accept     (accept)
   );

   // background issue: only in foreground-idle cycles
   assign issue = fl_idle && (cnt_cur != '0) && !live && !stale_full &&
                  !fifo_full && !push_busy && !reg_wr_en;

   assign fl_req  = issue;
   assign fl_addr = addr_cur;

   generate
      if (PUSH_REG) begin : g_push_reg
         logic          push_q;
         logic [DW-1:0] data_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               push_q <= 1'b0;
               data_q <= '0;
            end else begin
               push_q <= accept;
               if (accept) data_q <= fl_rdata;
            end
         end
         assign fifo_push  = push_q;
         assign fifo_wdata = data_q;
         assign push_busy  = push_q;
      end else begin : g_push_comb
         assign fifo_push  = accept;
         assign fifo_wdata = fl_rdata;
         assign push_busy  = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/fse_checker.sv
`timescale 1ns/1ps
module fse_checker
   import fse_pkg::*;
#(
   parameter int AW   = 24,
   parameter int CW   = 22,
   parameter int STEP = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_wr_en,
   input logic          reg_sel,
   input logic [CW-1:0] wr_cnt_val,
   input logic          fl_idle,
   input logic          fl_req,
   input logic [AW-1:0] fl_addr,
   input logic          fl_rvalid,
   input logic          fifo_full,
   input logic [CW-1:0] cnt,
   input logic          accept
);
   logic          have_last;
   logic [AW-1:0] last_addr;
   logic          cnt_wr;

   assign cnt_wr = reg_wr_en && (reg_sel == SEL_COUNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_last <= 1'b0;
         last_addr <= '0;
      end else if (reg_wr_en && reg_sel == SEL_ADDR) begin
         have_last <= 1'b0;
      end else if (fl_req) begin
         have_last <= 1'b1;
         last_addr <= fl_addr;
      end
   end

   p_idle_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req |-> fl_idle);

   p_full_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req |-> !fifo_full);

   p_one_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req |=> !fl_req);

   p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_req && have_last) |-> (fl_addr == AW'(last_addr + AW'(STEP))));

   p_count_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !cnt_wr) |=> (cnt == CW'($past(cnt) - 1'b1)));

   p_zero_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr && wr_cnt_val == '0) |=> (cnt == '0 && !fl_req));

   p_accept_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (fl_rvalid && cnt != '0));
endmodule

bind flash_stream_engine fse_checker #(.AW(AW), .CW(CW), .STEP(STEP)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr_en  (reg_wr_en),
   .reg_sel    (reg_sel),
   .wr_cnt_val (reg_wdata[CW-1:0]),
   .fl_idle    (fl_idle),
   .fl_req     (fl_req),
   .fl_addr    (fl_addr),
   .fl_rvalid  (fl_rvalid),
   .fifo_full  (fifo_full),
   .cnt        (cnt_cur),
   .accept     (accept)
);

// File: tb/tb_flash_stream_engine.sv
`timescale 1ns/1ps
module tb_flash_stream_engine;
   localparam int AW = 24;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr_en = 1'b0;
   logic          reg_sel = 1'b0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          fl_idle = 1'b1;
   logic          fl_req;
   logic [AW-1:0] fl_addr;
   logic          fl_rvalid = 1'b0;
   logic [DW-1:0] fl_rdata = '0;
   logic          fifo_full = 1'b0;
   logic          fifo_push;
   logic [DW-1:0] fifo_wdata;

   int total = 0;
   int bad = 0;
   bit done = 0;

   int lat = 2;
   int cyc = 0;
   int issued = 0;
   int max_inflight = 0;
   logic [AW-1:0] rq_addr[$];
   int            rq_due[$];
   logic [DW-1:0] pushq[$];

   always #2 clk = ~clk;

   flash_stream_engine dut (.*);

   function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
      return {8'h5A, a} ^ 32'h00C3_3C00;
   endfunction

   // flash responder and FIFO monitor
   initial begin
      forever begin
         @(negedge clk);
         #0.5;
         cyc++;
         if (fl_req === 1'b1) begin
            rq_addr.push_back(fl_addr);
            rq_due.push_back(cyc + lat);
            issued++;
         end
         if (rq_addr.size() > max_inflight) max_inflight = rq_addr.size();
         if (rq_due.size() > 0 && rq_due[0] <= cyc) begin
            fl_rvalid = 1'b1;
            fl_rdata  = pat(rq_addr[0]);
            void'(rq_addr.pop_front());
            void'(rq_due.pop_front());
         end else begin
            fl_rvalid = 1'b0;
         end
         #0.5;
         if (fifo_push === 1'b1) pushq.push_back(fifo_wdata);
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic sel, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic reg_read(input logic sel, output logic [31:0] v);
      @(negedge clk);
      reg_sel = sel;
      #0.2;
      v = reg_rdata;
   endtask

   task automatic idle_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_issue(input int n);
      for (int i = 0; i < 200 && issued < n; i++) @(negedge clk);
   endtask

   task automatic wait_pushes(input int n, input int limit);
      for (int i = 0; i < limit && pushq.size() < n; i++) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      reg_read(1'b1, v);
      chk(v == 0, "R1 count after reset", v, 0);
      reg_read(1'b0, v);
      chk(v == 0, "R1 address after reset", v, 0);
      chk(fl_req == 1'b0 && fifo_push == 1'b0, "R1 no request or push", {fl_req, fifo_push}, 0);
   endtask

   task automatic t_basic;
      logic [31:0] v;
      int base;
      pushq.delete(); lat = 2; base = issued;
      reg_write(1'b0, 32'h100);
      reg_write(1'b1, 32'd4);
      wait_pushes(1, 100);
      @(negedge clk);
      reg_read(1'b1, v);
      chk(v == 3, "R2 remaining count after first push", v, 3);
      wait_pushes(4, 200);
      idle_cycles(10);
      chk(pushq.size() == 4, "R5 push count", pushq.size(), 4);
      for (int i = 0; i < 4 && i < pushq.size(); i++)
         chk(pushq[i] == pat(AW'(32'h100 + 4*i)), "R4 R5 linear data", pushq[i], pat(AW'(32'h100 + 4*i)));
      chk(issued - base == 4, "R5 no request after zero", issued - base, 4);
      reg_read(1'b1, v);
      chk(v == 0, "R5 count reaches zero", v, 0);
      reg_read(1'b0, v);
      chk(v == 32'h110, "R4 address advanced", v, 32'h110);
   endtask

   task automatic t_busy;
      logic [31:0] v;
      int base;
      pushq.delete(); lat = 3; base = issued;
      fl_idle = 1'b0;
      reg_write(1'b0, 32'h300);
      reg_write(1'b1, 32'hFFC0_0003);
      reg_read(1'b1, v);
      chk(v == 3, "R2 upper count bits ignored", v, 3);
      idle_cycles(10);
      chk(issued == base, "R3 no request while flash busy", issued - base, 0);
      @(negedge clk); fl_idle = 1'b1;
      wait_pushes(3, 200);
      idle_cycles(5);
      chk(pushq.size() == 3, "R3 stream resumes when idle", pushq.size(), 3);
   endtask

   task automatic t_full;
      int base;
      pushq.delete(); lat = 2; base = issued;
      fifo_full = 1'b1;
      reg_write(1'b0, 32'h200);
      reg_write(1'b1, 32'd2);
      idle_cycles(10);
      chk(issued == base, "R7 no request while FIFO full", issued - base, 0);
      @(negedge clk); fifo_full = 1'b0;
      wait_pushes(2, 200);
      idle_cycles(5);
      chk(pushq.size() == 2 && pushq[0] == pat(AW'(32'h200)), "R7 stream after full clears",
          pushq.size(), 2);
   endtask

   task automatic t_outstanding;
      pushq.delete(); lat = 7; max_inflight = 0;
      reg_write(1'b0, 32'h340);
      reg_write(1'b1, 32'd3);
      wait_pushes(3, 300);
      idle_cycles(10);
      chk(max_inflight <= 1, "R7 single live read in flight", max_inflight, 1);
      chk(pushq.size() == 3, "R5 three words", pushq.size(), 3);
   endtask

   task automatic t_abort;
      logic [31:0] v;
      int base;
      pushq.delete(); lat = 20; base = issued;
      reg_write(1'b0, 32'h400);
      reg_write(1'b1, 32'd5);
      wait_issue(base + 1);
      reg_write(1'b1, 32'd0);
      reg_read(1'b1, v);
      chk(v == 0, "R6 count zero after cancel", v, 0);
      idle_cycles(4);
      chk(issued == base + 1, "R6 no request after cancel", issued - base, 1);
      reg_write(1'b0, 32'h800);
      reg_write(1'b1, 32'd2);
      idle_cycles(2);
      chk(issued == base + 2 && pushq.size() == 0, "R9 new stream issues before stale data",
          issued - base, 2);
      wait_pushes(2, 300);
      idle_cycles(30);
      chk(pushq.size() == 2, "R8 stale word not pushed", pushq.size(), 2);
      if (pushq.size() == 2) begin
         chk(pushq[0] == pat(AW'(32'h800)), "R8 first word from new stream", pushq[0], pat(AW'(32'h800)));
         chk(pushq[1] == pat(AW'(32'h804)), "R8 second word from new stream", pushq[1], pat(AW'(32'h804)));
      end
      reg_read(1'b1, v);
      chk(v == 0, "R8 stale response leaves count", v, 0);
   endtask

   task automatic t_stale_limit;
      logic [31:0] v;
      int base;
      pushq.delete(); lat = 40; base = issued;
      reg_write(1'b0, 32'hA00);
      for (int r = 0; r < 3; r++) begin
         reg_write(1'b1, 32'd5);
         wait_issue(base + r + 1);
         reg_write(1'b1, 32'd0);
      end
      reg_write(1'b1, 32'd1);
      idle_cycles(10);
      chk(issued == base + 3, "R9 issue held at stale limit", issued - base, 3);
      wait_pushes(1, 300);
      idle_cycles(50);
      chk(pushq.size() == 1, "R9 one word after limit", pushq.size(), 1);
      if (pushq.size() == 1)
         chk(pushq[0] == pat(AW'(32'hA0C)), "R9 word from next address", pushq[0], pat(AW'(32'hA0C)));
      reg_read(1'b1, v);
      chk(v == 0, "R9 count zero at end", v, 0);
   endtask

   task automatic t_addr_load;
      logic [31:0] v;
      reg_write(1'b0, 32'h0000_1237);
      reg_read(1'b0, v);
      chk(v == 32'h1234, "R10 aligned address load", v, 32'h1234);
   endtask

   initial begin
      #(4 * 20000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      idle_cycles(3);
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_basic();
      t_busy();
      t_full();
      t_outstanding();
      t_abort();
      t_stale_limit();
      t_addr_load();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule